// File: doc/BRIEF.md
# A/D Conversion Scan Controller

This block sequences analog-to-digital conversions across a programmable window of input channels. It holds a low and a high channel bound plus a current-channel pointer. It decides when a conversion may start, and it drives an ADC that is modelled as a start pulse answered by a busy level, a done pulse and a data word. Every result goes to a downstream FIFO write port one cycle after the converter reports it done.

A conversion sequence can be launched by a software strobe or, when the hardware clock is enabled, by a falling edge on either an internal timer output or an external trigger pin. In scan mode one launch walks the pointer from the low bound to the high bound. A programmable spacing, counted in ticks of a 10 MHz clock-enable, separates the samples. An optional external gate holds off a pending launch and freezes a scan in progress while it is low. Hardware launches that arrive while a sequence is active are dropped, and each one is flagged.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, busy_o, adc_start_o, fifo_wr_o and overrun_o are 0, and adc_chan_o is 0.
- R2: A write of the low bound (lo_wr_i) also loads the current pointer, and adc_chan_o shows the new value in the cycle after the write.
- R3: A software strobe starts a conversion only when no sequence is active and adc_busy_i is low. A strobe given while a sequence is active has no effect: it adds no result and raises no overrun.
- R4: While hwclk_en_i is 1 the software strobe is ignored: no conversion starts and busy_o stays 0.
- R5: With hwclk_en_i = 1, a launch is a falling edge of timer_i when hwclk_sel_i = 1, or a falling edge of ext_trig_i when hwclk_sel_i = 0. Rising edges and edges on the unselected source do nothing.
- R6: With scan_en_i = 1, one launch converts every channel from the low bound up to the high bound in ascending order. Each result is written to the FIFO one cycle after adc_done_i. busy_o stays 1 until the last result of the scan is written.
- R7: After the high bound is converted, the pointer returns to the low bound. When the two bounds are equal, a scan is one conversion.
- R8: Within a scan, the next adc_start_o is raised after N further tick_i cycles, counted from the cycle after the FIFO write. N is set by spacing_i: 0 gives 20 µs, 1 gives 15 µs, 2 gives 10 µs and 3 gives 4 µs, which at the default of 10 ticks per µs is 200, 150, 100 and 40 ticks. With tick_i always high, adc_start_o comes N cycles after the fifo_wr_o cycle.
- R9: With gate_en_i = 1, a launch taken while ext_gate_i is low issues no conversion until the gate goes high. Once the gate is high, the whole scan follows.
- R10: With gate_en_i = 1, a low gate during a scan stops new conversions and freezes the spacing count. The scan resumes when the gate returns high.
- R11: With scan_en_i = 0, each launch performs a single conversion and the pointer advances by one, wrapping from the high bound to the low bound. busy_o equals adc_busy_i.
- R12: Each hardware launch that arrives while a sequence is active is dropped and produces a one-cycle pulse on overrun_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | 10 MHz clock-enable tick for sample spacing |
| sw_start_i | input | 1 | Software start strobe |
| lo_wr_i | input | 1 | Write strobe for low bound (also loads pointer) |
| lo_chan_i | input | 5 | Low bound value |
| hi_wr_i | input | 1 | Write strobe for high bound |
| hi_chan_i | input | 5 | High bound value |
| scan_en_i | input | 1 | 1 = scan low..high per launch |
| hwclk_en_i | input | 1 | 1 = hardware launch, software strobe ignored |
| hwclk_sel_i | input | 1 | 1 = internal timer edge, 0 = external pin edge |
| gate_en_i | input | 1 | Enable external gating |
| spacing_i | input | 2 | Sample spacing code |
| timer_i | input | 1 | Internal timer output level |
| ext_trig_i | input | 1 | External trigger pin level |
| ext_gate_i | input | 1 | External gate level |
| adc_busy_i | input | 1 | Converter busy |
| adc_done_i | input | 1 | Converter result valid pulse |
| adc_data_i | input | 16 | Converter result |
| adc_start_o | output | 1 | Converter start pulse |
| adc_chan_o | output | 5 | Current channel pointer |
| busy_o | output | 1 | Conversion/scan in progress |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 16 | FIFO write data |
| overrun_o | output | 1 | Dropped-launch pulse |

## Verification
The bench measures the gap from each mid-scan FIFO write to the next start for all four spacing codes. A spacing table with a wrong entry, or a counter that is off by one tick, shows up there as a gap that differs from 200, 150, 100 or 40. Gating is tested in two ways: once before any conversion and once in the middle of a scan. A design that ignored the gate would produce starts and results while the gate was low. One that dropped the held launch would lose the whole scan. A second edge is driven during an active scan. A design that accepted it would produce extra results, and one that failed to flag it would leave overrun_o silent. A rising edge, an edge on the unselected source, and software strobes given in hardware mode or while busy are all applied. Any design that acts on them pushes results the scoreboard never expected.

// File: rtl/adc_scan_pkg.sv
// Shared types and helpers for the A/D scan controller.
// Assumes spacing codes are fixed at 2 bits and that tick rate is given per µs.
package adc_scan_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_CONV  = 2'd2,
        SQ_SPACE = 2'd3
    } seq_state_t;

    // Number of ticks between samples for a spacing code.
    function automatic int unsigned spacing_ticks(input logic [1:0] code,
                                                  input int unsigned tpu);
        case (code)
            2'b00:   return 20 * tpu;
            2'b01:   return 15 * tpu;
            2'b10:   return 10 * tpu;
            default: return 4 * tpu;
        endcase
    endfunction

endpackage

// File: rtl/adc_scan_trig.sv
// Launch source selection: software strobe, falling edge of internal timer
// or external pin, plus a registered external gate.
// Assumes input levels are already synchronous to clk.
module adc_scan_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_en_i,
    input  logic hw_sel_i,
    input  logic sw_start_i,
    input  logic timer_i,
    input  logic ext_i,
    input  logic gate_en_i,
    input  logic gate_i,
    output logic hw_trig_o,
    output logic sw_trig_o,
    output logic gate_ok_o
);
    logic [1:0] tmr_q;
    logic [1:0] ext_q;
    logic       gate_q;
    logic       tmr_fall;
    logic       ext_fall;

    // Two-stage history of each launch source plus a registered gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q  <= 2'b00;
            ext_q  <= 2'b00;
            gate_q <= 1'b1;
        end else begin
            tmr_q  <= {tmr_q[0], timer_i};
            ext_q  <= {ext_q[0], ext_i};
            gate_q <= gate_i;
        end
    end

    // Falling-edge detection and source selection.
    always_comb begin
        tmr_fall  = tmr_q[1] & ~tmr_q[0];
        ext_fall  = ext_q[1] & ~ext_q[0];
        hw_trig_o = hw_en_i & (hw_sel_i ? tmr_fall : ext_fall);
        sw_trig_o = sw_start_i & ~hw_en_i;
        gate_ok_o = ~gate_en_i | gate_q;
    end

endmodule

// File: rtl/adc_scan_ivl.sv
// Inter-sample spacing counter. Loaded with a tick count from the spacing
// code and counted down on each tick while run is high. Flags the last tick.
// Assumes load and run are never high in the same cycle.
module adc_scan_ivl #(
    parameter int unsigned TICKS_PER_US = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] code_i,
    input  logic       tick_i,
    input  logic       run_i,
    output logic       expired_o
);
    import adc_scan_pkg::*;

    localparam int unsigned MAX_TICKS = 20 * TICKS_PER_US;
    localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

    logic [CW-1:0] cnt;

    // Load on scan step, count down on ticks while allowed to run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load_i)
            cnt <= CW'(spacing_ticks(code_i, TICKS_PER_US));
        else if (run_i && tick_i && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // The final tick of the window ends the spacing.
    always_comb expired_o = run_i && tick_i && (cnt == CW'(1));

    // R8
    spacing_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(run_i && tick_i)) |=> $stable(cnt));

endmodule

// File: rtl/adc_scan_seq.sv
// Conversion sequencer: owns channel bounds and pointer, issues converter
// starts, steps through a scan, pushes results and flags dropped launches.
// Assumes the converter answers each start with exactly one done pulse.
module adc_scan_seq #(
    parameter int unsigned CH_W = 5,
    parameter int unsigned D_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lo_wr_i,
    input  logic [CH_W-1:0] lo_chan_i,
    input  logic            hi_wr_i,
    input  logic [CH_W-1:0] hi_chan_i,
    input  logic            scan_en_i,
    input  logic            hw_trig_i,
    input  logic            sw_trig_i,
    input  logic            gate_ok_i,
    input  logic            adc_busy_i,
    input  logic            adc_done_i,
    input  logic [D_W-1:0]  adc_data_i,
    input  logic            ivl_expired_i,
    output logic            ivl_load_o,
    output logic            ivl_run_o,
    output logic            adc_start_o,
    output logic [CH_W-1:0] adc_chan_o,
    output logic            busy_o,
    output logic            fifo_wr_o,
    output logic [D_W-1:0]  fifo_data_o,
    output logic            overrun_o
);
    import adc_scan_pkg::*;

    seq_state_t      st, st_nxt;
    logic [CH_W-1:0] lo_q, hi_q, ptr_q;
    logic            accept;
    logic            at_top;
    logic            step;

    // Next-state and strobe decode for the scan sequence.
    always_comb begin
        st_nxt      = st;
        adc_start_o = 1'b0;
        ivl_load_o  = 1'b0;
        at_top      = (ptr_q == hi_q);
        step        = (st == SQ_CONV) && adc_done_i;
        accept      = (st == SQ_IDLE) && (hw_trig_i || (sw_trig_i && !adc_busy_i));
        case (st)
            SQ_IDLE:  if (accept) st_nxt = SQ_ISSUE;
            SQ_ISSUE: if (gate_ok_i) begin
                          adc_start_o = 1'b1;
                          st_nxt      = SQ_CONV;
                      end
            SQ_CONV:  if (adc_done_i) begin
                          if (scan_en_i && !at_top) begin
                              st_nxt     = SQ_SPACE;
                              ivl_load_o = 1'b1;
                          end else begin
                              st_nxt = SQ_IDLE;
                          end
                      end
            SQ_SPACE: if (ivl_expired_i) st_nxt = SQ_ISSUE;
            default:  st_nxt = SQ_IDLE;
        endcase
        ivl_run_o  = (st == SQ_SPACE) && gate_ok_i;
        busy_o     = scan_en_i ? (st != SQ_IDLE) : adc_busy_i;
        adc_chan_o = ptr_q;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nxt;
    end

    // Channel bounds and current pointer; a low-bound write reloads the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            ptr_q <= '0;
        end else begin
            if (lo_wr_i) lo_q <= lo_chan_i;
            if (hi_wr_i) hi_q <= hi_chan_i;
            if (lo_wr_i)   ptr_q <= lo_chan_i;
            else if (step) ptr_q <= at_top ? lo_q : ptr_q + 1'b1;
        end
    end

    // Result push and dropped-launch flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr_o   <= 1'b0;
            fifo_data_o <= '0;
            overrun_o   <= 1'b0;
        end else begin
            fifo_wr_o   <= step;
            if (step) fifo_data_o <= adc_data_i;
            overrun_o   <= hw_trig_i && (st != SQ_IDLE);
        end
    end

    // R6
    result_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == SQ_CONV) && adc_done_i) |=> fifo_wr_o);

    // R12
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> ($past(st) != SQ_IDLE));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == SQ_IDLE) && !hw_trig_i && !sw_trig_i) |=> (st == SQ_IDLE));

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |=> !adc_start_o);

endmodule

// File: rtl/adc_scan_ctrl.sv
// Top of the A/D scan controller: joins launch selection, the sequencer
// and the spacing counter. Assumes all inputs are synchronous to clk.
module adc_scan_ctrl #(
    parameter int unsigned CH_W         = 5,
    parameter int unsigned D_W          = 16,
    parameter int unsigned TICKS_PER_US = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            sw_start_i,
    input  logic            lo_wr_i,
    input  logic [CH_W-1:0] lo_chan_i,
    input  logic            hi_wr_i,
    input  logic [CH_W-1:0] hi_chan_i,
    input  logic            scan_en_i,
    input  logic            hwclk_en_i,
    input  logic            hwclk_sel_i,
    input  logic            gate_en_i,
    input  logic [1:0]      spacing_i,
    input  logic            timer_i,
    input  logic            ext_trig_i,
    input  logic            ext_gate_i,
    input  logic            adc_busy_i,
    input  logic            adc_done_i,
    input  logic [D_W-1:0]  adc_data_i,
    output logic            adc_start_o,
    output logic [CH_W-1:0] adc_chan_o,
    output logic            busy_o,
    output logic            fifo_wr_o,
    output logic [D_W-1:0]  fifo_data_o,
    output logic            overrun_o
);
    logic hw_trig, sw_trig, gate_ok;
    logic ivl_load, ivl_run, ivl_expired;

    adc_scan_trig u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_en_i    (hwclk_en_i),
        .hw_sel_i   (hwclk_sel_i),
        .sw_start_i (sw_start_i),
        .timer_i    (timer_i),
        .ext_i      (ext_trig_i),
        .gate_en_i  (gate_en_i),
        .gate_i     (ext_gate_i),
        .hw_trig_o  (hw_trig),
        .sw_trig_o  (sw_trig),
        .gate_ok_o  (gate_ok)
    );

    adc_scan_seq #(.CH_W(CH_W), .D_W(D_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .lo_wr_i       (lo_wr_i),
        .lo_chan_i     (lo_chan_i),
        .hi_wr_i       (hi_wr_i),
        .hi_chan_i     (hi_chan_i),
        .scan_en_i     (scan_en_i),
        .hw_trig_i     (hw_trig),
        .sw_trig_i     (sw_trig),
        .gate_ok_i     (gate_ok),
        .adc_busy_i    (adc_busy_i),
        .adc_done_i    (adc_done_i),
        .adc_data_i    (adc_data_i),
        .ivl_expired_i (ivl_expired),
        .ivl_load_o    (ivl_load),
        .ivl_run_o     (ivl_run),
        .adc_start_o   (adc_start_o),
        .adc_chan_o    (adc_chan_o),
        .busy_o        (busy_o),
        .fifo_wr_o     (fifo_wr_o),
        .fifo_data_o   (fifo_data_o),
        .overrun_o     (overrun_o)
    );

    adc_scan_ivl #(.TICKS_PER_US(TICKS_PER_US)) u_ivl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ivl_load),
        .code_i    (spacing_i),
        .tick_i    (tick_i),
        .run_i     (ivl_run),
        .expired_o (ivl_expired)
    );

    // R10
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_i && !gate_ok) |-> !adc_start_o);

endmodule

// File: tb/adc_scan_ctrl_tb_top.sv
// Scoreboard bench: tests push expected channels, a monitor pops them on
// every FIFO write; a negedge model plays the converter.
module adc_scan_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CONV_CYC   = 6;

    logic clk = 0;
    logic rst_n = 0;
    logic tick_i = 1, sw_start_i = 0, lo_wr_i = 0, hi_wr_i = 0;
    logic [4:0] lo_chan_i = 0, hi_chan_i = 0;
    logic scan_en_i = 1, hwclk_en_i = 0, hwclk_sel_i = 0, gate_en_i = 0;
    logic [1:0] spacing_i = 2'b11;
    logic timer_i = 1, ext_trig_i = 1, ext_gate_i = 1;
    logic adc_busy_i = 0, adc_done_i = 0;
    logic [15:0] adc_data_i = 0;
    logic adc_start_o, busy_o, fifo_wr_o, overrun_o;
    logic [4:0] adc_chan_o;
    logic [15:0] fifo_data_o;

    int vec = 0, err = 0;
    int n_wr = 0, n_start = 0, n_ovr = 0;
    int cc = 0;
    logic [4:0] lat = 0;
    bit busy_cmp = 0;
    bit finished = 0;
    logic [4:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sw_start_i(sw_start_i),
        .lo_wr_i(lo_wr_i), .lo_chan_i(lo_chan_i), .hi_wr_i(hi_wr_i), .hi_chan_i(hi_chan_i),
        .scan_en_i(scan_en_i), .hwclk_en_i(hwclk_en_i), .hwclk_sel_i(hwclk_sel_i),
        .gate_en_i(gate_en_i), .spacing_i(spacing_i), .timer_i(timer_i),
        .ext_trig_i(ext_trig_i), .ext_gate_i(ext_gate_i), .adc_busy_i(adc_busy_i),
        .adc_done_i(adc_done_i), .adc_data_i(adc_data_i), .adc_start_o(adc_start_o),
        .adc_chan_o(adc_chan_o), .busy_o(busy_o), .fifo_wr_o(fifo_wr_o),
        .fifo_data_o(fifo_data_o), .overrun_o(overrun_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        vec++;
        if (act != exp) begin
            err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Converter model: answers a start with CONV_CYC busy cycles then done.
    always @(negedge clk) begin
        if (busy_cmp) chk("R11 busy follows converter", int'(busy_o), int'(adc_busy_i));
        adc_done_i = 0;
        if (adc_busy_i) begin
            if (cc == 1) begin
                adc_busy_i = 0;
                adc_done_i = 1;
                adc_data_i = 16'hC000 | 16'(lat);
            end else cc--;
        end else if (adc_start_o) begin
            adc_busy_i = 1;
            cc = CONV_CYC;
            lat = adc_chan_o;
        end
    end

    // Monitor: pops the scoreboard on each FIFO write, counts starts and overruns.
    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_start_o) n_start++;
            if (overrun_o) n_ovr++;
            if (fifo_wr_o) begin
                n_wr++;
                if (expq.size() == 0) begin
                    chk("R6 unexpected result", int'(fifo_data_o), -1);
                end else begin
                    logic [4:0] e;
                    e = expq.pop_front();
                    chk("R6 result channel order", int'(fifo_data_o), int'(16'hC000 | 16'(e)));
                    if (scan_en_i && expq.size() != 0)
                        chk("R6 busy held mid-scan", int'(busy_o), 1);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_go();
        sw_start_i = 1; cyc(1); sw_start_i = 0;
    endtask

    task automatic set_lo(input logic [4:0] v);
        lo_chan_i = v; lo_wr_i = 1; cyc(1); lo_wr_i = 0;
    endtask

    task automatic set_hi(input logic [4:0] v);
        hi_chan_i = v; hi_wr_i = 1; cyc(1); hi_wr_i = 0;
    endtask

    task automatic push_scan(input int lo, input int hi);
        for (int c = lo; c <= hi; c++) expq.push_back(5'(c));
    endtask

    task automatic drain(input string req);
        int t = 0;
        while ((expq.size() != 0 || busy_o) && t < 5000) begin cyc(1); t++; end
        chk(req, expq.size(), 0);
        cyc(2);
    endtask

    initial begin
        int w0, s0, o0, n;
        int exp_n[4];
        exp_n = '{200, 150, 100, 40};
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 start", int'(adc_start_o), 0);
        chk("R1 fifo_wr", int'(fifo_wr_o), 0);
        chk("R1 chan", int'(adc_chan_o), 0);
        chk("R1 overrun", int'(overrun_o), 0);

        // R2 low write loads pointer
        set_lo(5'd5);
        chk("R2 pointer load", int'(adc_chan_o), 5);

        // R6 software scan 3..6
        set_lo(5'd3); set_hi(5'd6);
        w0 = n_wr;
        push_scan(3, 6);
        sw_go();
        chk("R6 busy after launch", int'(busy_o), 1);
        drain("R6 scan complete");
        chk("R6 result count", n_wr - w0, 4);
        chk("R7 wrap to low", int'(adc_chan_o), 3);

        // R7 single-channel scan
        set_lo(5'd7); set_hi(5'd7);
        w0 = n_wr;
        push_scan(7, 7);
        sw_go();
        drain("R7 single scan");
        chk("R7 one result", n_wr - w0, 1);

        // R3 strobe while busy ignored
        set_lo(5'd0); set_hi(5'd3);
        w0 = n_wr; o0 = n_ovr;
        push_scan(0, 3);
        sw_go(); cyc(5); sw_go();
        drain("R3 scan with extra strobe");
        chk("R3 no extra results", n_wr - w0, 4);
        chk("R3 no overrun", n_ovr - o0, 0);

        // R4 strobe ignored in hardware mode
        hwclk_en_i = 1; hwclk_sel_i = 1;
        cyc(3);
        w0 = n_wr;
        sw_go(); cyc(50);
        chk("R4 no result", n_wr - w0, 0);
        chk("R4 not busy", int'(busy_o), 0);

        // R5 internal timer falling edge
        w0 = n_wr;
        push_scan(0, 3);
        timer_i = 0;
        cyc(3);
        drain("R5 timer launch");
        chk("R5 timer results", n_wr - w0, 4);
        w0 = n_wr;
        timer_i = 1; cyc(30);
        chk("R5 rising edge ignored", n_wr - w0, 0);
        hwclk_sel_i = 0;
        cyc(2);
        timer_i = 0; cyc(30);
        chk("R5 unselected source ignored", n_wr - w0, 0);
        timer_i = 1; cyc(2);
        push_scan(0, 3);
        ext_trig_i = 0; cyc(3);
        drain("R5 external launch");
        chk("R5 external results", n_wr - w0, 4);
        ext_trig_i = 1; cyc(3);

        // R8 spacing codes
        set_lo(5'd0); set_hi(5'd1);
        for (int k = 0; k < 4; k++) begin
            spacing_i = 2'(k);
            push_scan(0, 1);
            ext_trig_i = 0;
            while (!fifo_wr_o) cyc(1);
            n = 0;
            do begin cyc(1); n++; end while (!adc_start_o && n < 1000);
            chk("R8 spacing gap", n, exp_n[k]);
            drain("R8 spacing scan");
            ext_trig_i = 1; cyc(3);
        end
        spacing_i = 2'b11;

        // R9 gate low before launch
        gate_en_i = 1; ext_gate_i = 0;
        cyc(3);
        w0 = n_wr; s0 = n_start;
        push_scan(0, 1);
        ext_trig_i = 0; cyc(100);
        chk("R9 held: no start", n_start - s0, 0);
        chk("R9 held: no result", n_wr - w0, 0);
        ext_gate_i = 1;
        drain("R9 released scan");
        chk("R9 results after gate", n_wr - w0, 2);
        ext_trig_i = 1; cyc(3);

        // R10 gate low mid-scan
        set_hi(5'd2);
        w0 = n_wr;
        push_scan(0, 2);
        ext_trig_i = 0;
        while (!fifo_wr_o) cyc(1);
        ext_gate_i = 0;
        cyc(2);
        s0 = n_start;
        cyc(300);
        chk("R10 paused: no start", n_start - s0, 0);
        chk("R10 paused: one result", n_wr - w0, 1);
        ext_gate_i = 1;
        drain("R10 resumed scan");
        chk("R10 total results", n_wr - w0, 3);
        ext_trig_i = 1; cyc(3);
        gate_en_i = 0;

        // R12 launch dropped during scan
        set_hi(5'd3);
        w0 = n_wr; o0 = n_ovr;
        push_scan(0, 3);
        ext_trig_i = 0; cyc(8);
        ext_trig_i = 1; cyc(2);
        ext_trig_i = 0;
        drain("R12 scan with extra edge");
        chk("R12 overrun pulses", n_ovr - o0, 1);
        chk("R12 no extra results", n_wr - w0, 4);
        ext_trig_i = 1; cyc(3);

        // R11 single conversions with pointer stepping
        hwclk_en_i = 0; scan_en_i = 0;
        set_lo(5'd2); set_hi(5'd3);
        busy_cmp = 1;
        w0 = n_wr;
        push_scan(2, 2);
        sw_go();
        drain("R11 first single");
        chk("R11 pointer advanced", int'(adc_chan_o), 3);
        push_scan(3, 3);
        sw_go();
        drain("R11 second single");
        chk("R11 pointer wrapped", int'(adc_chan_o), 2);
        chk("R11 result count", n_wr - w0, 2);
        busy_cmp = 0;

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vec++; err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, err);
            $finish;
        end
    end

endmodule